// File: doc/BRIEF.md
# Boot-Block Flash Command Interface

A synthesizable model of a byte-wide boot-block flash part, centred on its command decoder. A host drives a synchronous bus (address, write data, write strobe, read strobe) and gets registered read data back. Every byte written outside a pending two-cycle sequence becomes the current command. The command decides what later reads return: array contents, identifier codes or the status byte. Two-cycle sequences program a single byte or erase a whole block. Both complete in one clock.

The array is divided into four blocks: one main block, two small data blocks and a boot block. The boot block can never be programmed or erased. Parameter `TOP_BOOT` places the boot block at the high or the low end of the array. Parameter `INV_HI` flips the most significant address bit before any decode. `AW` sets the array size to 2**AW bytes (bit 16 at the full 128 KB size), and the block boundaries scale with it. After reset every array byte reads 0xFF. Reading and writing in the same cycle is not supported.

Top module: `flash_cui`

## Requirements
- R1: Reset state: `rdata_o` is 0x00, the mode is array read, the status byte is 0x00 and every array byte is 0xFF.
- R2: While the mode is array read (after command 0xFF), a read returns the array byte at the decoded address on `rdata_o`. The value appears one clock after the edge that samples `re_i`. `rdata_o` holds its value in cycles without a read.
- R3: Command 0x90 selects identifier mode. A read with decoded address bit 0 clear returns 0x89. With bit 0 set, it returns 0x94 when TOP_BOOT=1 and 0x95 when TOP_BOOT=0.
- R4: Command 0x70 selects status mode, and reads then return the status byte. Command 0x50 sets the status byte to 0x00 and selects array reads.
- R5: Command 0x40 or 0x10 latches the decoded write address. The next write stores its data only if its decoded address equals the latched one. Otherwise the array is unchanged.
- R6: Command 0x20 followed by a write of 0xD0 sets every byte of the block that holds the second write's address to 0xFF. Bytes in the other blocks are unchanged.
- R7: Command 0x20 followed by any byte other than 0xD0 leaves the array and the status byte unchanged and selects status mode.
- R8: The second write of a program sequence, or a 0xD0 erase confirm, selects status mode and sets the status byte to 0x80. This holds even when the array is not modified.
- R9: A program write or an erase confirm whose address falls in the boot block leaves the array unchanged.
- R10: With size S=2**AW and TOP_BOOT=0, the blocks are: boot [0, S/16), data 1 [S/16, 3S/32), data 2 [3S/32, S/8), main [S/8, S). With TOP_BOOT=1 they are: main [0, 7S/8), data 1 [7S/8, 29S/32), data 2 [29S/32, 15S/16), boot [15S/16, S).
- R11: With INV_HI=1, address bit AW-1 is inverted before the array access, identifier decode, block decode and program address latch.
- R12: A write outside a pending sequence that is not a recognised command (0xFF, 0x90, 0x70, 0x50, 0x40, 0x10, 0x20) makes reads return array data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | AW | Byte address |
| wdata_i | input | 8 | Write data or command byte |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Registered read data |

## Verification
Some properties are checked on every cycle. Read data holds when there is no read. A clear command empties the status byte. A completed sequence sets it to ready. Identifier and status reads return the right bytes one clock later. No program strobe ever reaches the boot block. Other behaviour needs the bench's scenarios against a reference model: which bytes an erase clears at block edges for both layouts, address matching on the program cycle, aborted erases, and how the inverted address bit moves data between halves of the array.

// File: rtl/flash_cui_pkg.sv
package flash_cui_pkg;

  typedef enum logic [1:0] {RG_MAIN, RG_DATA1, RG_DATA2, RG_BOOT} region_e;
  typedef enum logic [1:0] {SEQ_IDLE, SEQ_PROG, SEQ_ERASE} seq_e;
  typedef enum logic [1:0] {RD_ARRAY, RD_IDENT, RD_STATUS} rd_sel_e;

  localparam logic [7:0] CMD_READ_ARRAY  = 8'hFF;
  localparam logic [7:0] CMD_IDENT       = 8'h90;
  localparam logic [7:0] CMD_READ_STATUS = 8'h70;
  localparam logic [7:0] CMD_CLR_STATUS  = 8'h50;
  localparam logic [7:0] CMD_PROG        = 8'h40;
  localparam logic [7:0] CMD_PROG_ALT    = 8'h10;
  localparam logic [7:0] CMD_ERASE       = 8'h20;
  localparam logic [7:0] CMD_CONFIRM     = 8'hD0;

  localparam logic [7:0] MFR_CODE  = 8'h89;
  localparam logic [7:0] DEV_TOP   = 8'h94;
  localparam logic [7:0] DEV_BOT   = 8'h95;
  localparam logic [7:0] ST_READY  = 8'h80;

  // block decode, boundaries in fractions of array size sz
  function automatic region_e region_of(int unsigned a, int unsigned sz, bit top);
    region_e r;
    if (top) begin
      if (a < sz / 8 * 7)                 r = RG_MAIN;
      else if (a < sz / 32 * 29)          r = RG_DATA1;
      else if (a < sz / 16 * 15)          r = RG_DATA2;
      else                                r = RG_BOOT;
    end else begin
      if (a < sz / 16)                    r = RG_BOOT;
      else if (a < sz / 32 * 3)           r = RG_DATA1;
      else if (a < sz / 8)                r = RG_DATA2;
      else                                r = RG_MAIN;
    end
    return r;
  endfunction

endpackage

// File: rtl/flash_addr_map.sv
module flash_addr_map
  import flash_cui_pkg::*;
#(
  parameter int unsigned AW       = 11,
  parameter bit          TOP_BOOT = 1'b1,
  parameter bit          INV_HI   = 1'b0
) (
  input  logic [AW-1:0] addr_i,
  output logic [AW-1:0] addr_o,
  output region_e       region_o
);
  localparam int unsigned SZ = 1 << AW;
  localparam logic [AW-1:0] FLIP = INV_HI ? (AW'(1) << (AW - 1)) : '0;

  assign addr_o = addr_i ^ FLIP;

  always_comb region_o = region_of(32'(addr_o), SZ, TOP_BOOT);

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cui_pkg::*;
#(
  parameter int unsigned AW = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] addr_i,
  input  region_e       region_i,
  output rd_sel_e       rd_sel_o,
  output logic [7:0]    status_o,
  output seq_e          seq_o,
  output logic          prog_we_o,
  output logic          erase_go_o,
  output region_e       erase_region_o
);
  rd_sel_e       rd_sel_q;
  seq_e          seq_q;
  logic [7:0]    status_q;
  logic [AW-1:0] prog_addr_q;

  assign rd_sel_o       = rd_sel_q;
  assign status_o       = status_q;
  assign seq_o          = seq_q;
  assign erase_region_o = region_i;

  always_comb begin
    prog_we_o  = we_i && (seq_q == SEQ_PROG) && (addr_i == prog_addr_q)
                 && (region_i != RG_BOOT);
    erase_go_o = we_i && (seq_q == SEQ_ERASE) && (wdata_i == CMD_CONFIRM)
                 && (region_i != RG_BOOT);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_sel_q    <= RD_ARRAY;
      seq_q       <= SEQ_IDLE;
      status_q    <= 8'h00;
      prog_addr_q <= '0;
    end else if (we_i) begin
      unique case (seq_q)
        SEQ_PROG: begin
          rd_sel_q <= RD_STATUS;
          status_q <= ST_READY;
          seq_q    <= SEQ_IDLE;
        end
        SEQ_ERASE: begin
          rd_sel_q <= RD_STATUS;
          if (wdata_i == CMD_CONFIRM) status_q <= ST_READY;
          seq_q    <= SEQ_IDLE;
        end
        default: begin
          unique case (wdata_i)
            CMD_IDENT:       rd_sel_q <= RD_IDENT;
            CMD_READ_STATUS: rd_sel_q <= RD_STATUS;
            CMD_CLR_STATUS: begin
              rd_sel_q <= RD_ARRAY;
              status_q <= 8'h00;
            end
            CMD_PROG, CMD_PROG_ALT: begin
              rd_sel_q    <= RD_ARRAY;
              prog_addr_q <= addr_i;
              seq_q       <= SEQ_PROG;
            end
            CMD_ERASE: begin
              rd_sel_q <= RD_ARRAY;
              seq_q    <= SEQ_ERASE;
            end
            default:         rd_sel_q <= RD_ARRAY;
          endcase
        end
      endcase
    end
  end

endmodule

// File: rtl/flash_store.sv
module flash_store
  import flash_cui_pkg::*;
#(
  parameter int unsigned AW       = 11,
  parameter bit          TOP_BOOT = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          prog_we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  input  logic          erase_go_i,
  input  region_e       erase_region_i,
  output logic [7:0]    rdata_o
);
  localparam int unsigned SZ = 1 << AW;

  logic [SZ*8-1:0] flat;

  for (genvar i = 0; i < SZ; i++) begin : g_byte
    localparam region_e RG = region_of(i, SZ, TOP_BOOT);
    logic [7:0] byte_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   byte_q <= 8'hFF;
      else if (erase_go_i && erase_region_i == RG)   byte_q <= 8'hFF;
      else if (prog_we_i && addr_i == AW'(i))        byte_q <= wdata_i;
    end
    assign flat[i*8 +: 8] = byte_q;
  end

  assign rdata_o = flat[32'(addr_i)*8 +: 8];

endmodule

// File: rtl/flash_cui.sv
module flash_cui
  import flash_cui_pkg::*;
#(
  parameter int unsigned AW       = 11,
  parameter bit          TOP_BOOT = 1'b1,
  parameter bit          INV_HI   = 1'b0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  input  logic          we_i,
  input  logic          re_i,
  output logic [7:0]    rdata_o
);
  localparam logic [7:0] DEV_CODE = TOP_BOOT ? DEV_TOP : DEV_BOT;

  logic [AW-1:0] addr_m;
  region_e       region;
  rd_sel_e       rd_sel;
  seq_e          seq;
  logic [7:0]    status;
  logic          prog_we;
  logic          erase_go;
  region_e       erase_region;
  logic [7:0]    arr_rdata;

  flash_addr_map #(.AW(AW), .TOP_BOOT(TOP_BOOT), .INV_HI(INV_HI)) i_map (
    .addr_i   (addr_i),
    .addr_o   (addr_m),
    .region_o (region)
  );

  flash_cmd_ctrl #(.AW(AW)) i_ctrl (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .we_i           (we_i),
    .wdata_i        (wdata_i),
    .addr_i         (addr_m),
    .region_i       (region),
    .rd_sel_o       (rd_sel),
    .status_o       (status),
    .seq_o          (seq),
    .prog_we_o      (prog_we),
    .erase_go_o     (erase_go),
    .erase_region_o (erase_region)
  );

  flash_store #(.AW(AW), .TOP_BOOT(TOP_BOOT)) i_store (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .prog_we_i      (prog_we),
    .addr_i         (addr_m),
    .wdata_i        (wdata_i),
    .erase_go_i     (erase_go),
    .erase_region_i (erase_region),
    .rdata_o        (arr_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= 8'h00;
    else if (re_i) begin
      unique case (rd_sel)
        RD_IDENT:  rdata_o <= addr_m[0] ? DEV_CODE : MFR_CODE;
        RD_STATUS: rdata_o <= status;
        default:   rdata_o <= arr_rdata;
      endcase
    end
  end

endmodule

// File: rtl/flash_cui_chk.sv
module flash_cui_chk
  import flash_cui_pkg::*;
#(
  parameter int unsigned AW       = 11,
  parameter bit          TOP_BOOT = 1'b1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          we_i,
  input logic          re_i,
  input logic [7:0]    wdata_i,
  input logic [AW-1:0] addr_m,
  input logic [7:0]    rdata_o,
  input rd_sel_e       rd_sel,
  input seq_e          seq,
  input logic [7:0]    status,
  input logic          prog_we,
  input region_e       region
);
  localparam logic [7:0] DEV_CODE = TOP_BOOT ? DEV_TOP : DEV_BOT;

  a_r2_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> $stable(rdata_o));

  a_r3_ident_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && rd_sel == RD_IDENT) |=> rdata_o == ($past(addr_m[0]) ? DEV_CODE : MFR_CODE));

  a_r4_status_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && rd_sel == RD_STATUS) |=> rdata_o == $past(status));

  a_r4_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && seq == SEQ_IDLE && wdata_i == CMD_CLR_STATUS) |=> status == 8'h00);

  a_r8_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && (seq == SEQ_PROG || (seq == SEQ_ERASE && wdata_i == CMD_CONFIRM)))
      |=> (status == ST_READY && rd_sel == RD_STATUS));

  a_r9_boot_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_we |-> region != RG_BOOT);

endmodule

bind flash_cui flash_cui_chk #(.AW(AW), .TOP_BOOT(TOP_BOOT)) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .we_i    (we_i),
  .re_i    (re_i),
  .wdata_i (wdata_i),
  .addr_m  (addr_m),
  .rdata_o (rdata_o),
  .rd_sel  (rd_sel),
  .seq     (seq),
  .status  (status),
  .prog_we (prog_we),
  .region  (region)
);

// File: tb/test_flash_cui.sv
module test_flash_cui;
  localparam int AW = 11;
  localparam int SZ = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    wdata = 8'h00;
  logic          we = 1'b0;
  logic          re = 1'b0;
  logic [7:0]    rd0, rd1;

  always #5 clk = ~clk;

  flash_cui #(.AW(AW), .TOP_BOOT(1'b1), .INV_HI(1'b0)) i_flash_cui (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .wdata_i(wdata),
    .we_i(we), .re_i(re), .rdata_o(rd0));

  flash_cui #(.AW(AW), .TOP_BOOT(1'b0), .INV_HI(1'b1)) i_flash_cui_b (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .wdata_i(wdata),
    .we_i(we), .re_i(re), .rdata_o(rd1));

  int total = 0, bad = 0;
  bit done = 0;

  // reference model, device 0: top boot, device 1: bottom boot with inverted high bit
  logic [7:0] mdl_mem [2][SZ];
  int         mdl_sel [2];   // 0 array, 1 ident, 2 status
  logic [7:0] mdl_st  [2];
  int         mdl_seq [2];   // 0 idle, 1 prog, 2 erase
  int         mdl_pa  [2];
  bit         dev_top [2] = '{1'b1, 1'b0};
  bit         dev_inv [2] = '{1'b0, 1'b1};

  typedef struct { logic [7:0] e0; logic [7:0] e1; string tag; int a; } exp_t;
  exp_t sb[$];

  function automatic int rgn(int a, bit top);  // 0 main 1 data1 2 data2 3 boot (R10)
    if (top) begin
      if (a < SZ*7/8) return 0;
      if (a < SZ*29/32) return 1;
      if (a < SZ*15/16) return 2;
      return 3;
    end
    if (a < SZ/16) return 3;
    if (a < SZ*3/32) return 1;
    if (a < SZ/8) return 2;
    return 0;
  endfunction

  function automatic int phys(int d, int a);
    return dev_inv[d] ? (a ^ (SZ/2)) : a;
  endfunction

  task automatic mdl_wr(int d, int a, logic [7:0] v);
    int p = phys(d, a);
    int r = rgn(p, dev_top[d]);
    if (mdl_seq[d] == 1) begin
      if (p == mdl_pa[d] && r != 3) mdl_mem[d][p] = v;
      mdl_sel[d] = 2; mdl_st[d] = 8'h80; mdl_seq[d] = 0;
    end else if (mdl_seq[d] == 2) begin
      if (v == 8'hD0) begin
        if (r != 3)
          for (int k = 0; k < SZ; k++)
            if (rgn(k, dev_top[d]) == r) mdl_mem[d][k] = 8'hFF;
        mdl_st[d] = 8'h80;
      end
      mdl_sel[d] = 2; mdl_seq[d] = 0;
    end else begin
      case (v)
        8'h90: mdl_sel[d] = 1;
        8'h70: mdl_sel[d] = 2;
        8'h50: begin mdl_sel[d] = 0; mdl_st[d] = 8'h00; end
        8'h40, 8'h10: begin mdl_sel[d] = 0; mdl_pa[d] = p; mdl_seq[d] = 1; end
        8'h20: begin mdl_sel[d] = 0; mdl_seq[d] = 2; end
        default: mdl_sel[d] = 0;
      endcase
    end
  endtask

  function automatic logic [7:0] mdl_rd(int d, int a);
    int p = phys(d, a);
    case (mdl_sel[d])
      1: return p[0] ? (dev_top[d] ? 8'h94 : 8'h95) : 8'h89;
      2: return mdl_st[d];
      default: return mdl_mem[d][p];
    endcase
  endfunction

  task automatic chk(string tag, int a, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s addr=%0h actual=%02h expected=%02h", tag, a, act, exp);
    end
  endtask

  task automatic wr(int a, logic [7:0] v);
    @(negedge clk);
    addr = AW'(a); wdata = v; we = 1'b1; re = 1'b0;
    mdl_wr(0, a, v);
    mdl_wr(1, a, v);
  endtask

  task automatic rd(int a, string tag);
    exp_t e;
    @(negedge clk);
    addr = AW'(a); we = 1'b0; re = 1'b1;
    e.e0 = mdl_rd(0, a); e.e1 = mdl_rd(1, a); e.tag = tag; e.a = a;
    sb.push_back(e);
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      we = 1'b0; re = 1'b0;
    end
  endtask

  task automatic prog(int a, logic [7:0] v);
    wr(a, 8'h40);
    wr(a, v);
  endtask

  // monitor: read sampled at an edge appears after it, compared at the next negedge
  initial begin
    forever begin
      @(posedge clk);
      if (rst_ni && re) begin
        exp_t e;
        @(negedge clk);
        if (sb.size() == 0) begin
          total++; bad++;
          $display("FAIL R2 unexpected read result actual=%02h expected=none", rd0);
        end else begin
          e = sb.pop_front();
          chk({e.tag, " top"}, e.a, rd0, e.e0);
          chk({e.tag, " bot"}, e.a, rd1, e.e1);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    for (int d = 0; d < 2; d++) begin
      for (int k = 0; k < SZ; k++) mdl_mem[d][k] = 8'hFF;
      mdl_sel[d] = 0; mdl_st[d] = 8'h00; mdl_seq[d] = 0; mdl_pa[d] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset rdata", 0, rd0, 8'h00);
    chk("R1 reset rdata", 0, rd1, 8'h00);
    rst_ni = 1'b1;

    // R1 erased array, status clear
    rd(12'h005, "R1 erased byte");
    rd(12'h7FF, "R1 erased byte");
    wr(0, 8'h70);
    rd(0, "R1 status after reset");

    // R5 R8 program in main, R2 read back
    prog(12'h300, 8'hA5);
    rd(12'h300, "R8 status after program");
    wr(0, 8'hFF);
    rd(12'h300, "R2 R5 programmed byte");
    idle(2);
    rd(12'h300, "R2 repeat read");

    // R5 alternate setup, mismatched address is dropped
    wr(12'h301, 8'h10);
    wr(12'h302, 8'h3C);
    rd(12'h302, "R8 status after failed program");
    wr(0, 8'hFF);
    rd(12'h301, "R5 mismatched address");
    rd(12'h302, "R5 mismatched address");
    wr(12'h303, 8'h10);
    wr(12'h303, 8'h77);
    wr(0, 8'hFF);
    rd(12'h303, "R5 alternate setup");

    // R9 R11 boot of top device, main of inverted bottom device
    prog(12'h790, 8'h5A);
    rd(0, "R8 R9 status after boot program");
    wr(0, 8'hFF);
    rd(12'h790, "R9 R11 boot program");
    prog(12'h47F, 8'h66);
    wr(0, 8'hFF);
    rd(12'h47F, "R9 R10 R11 boot edge");

    // R3 identifier codes
    wr(0, 8'h90);
    rd(12'h000, "R3 manufacturer");
    rd(12'h001, "R3 device code");
    rd(12'h402, "R3 manufacturer high half");
    rd(12'h7FF, "R3 device code high half");

    // R4 status clear
    wr(0, 8'h70);
    rd(0, "R4 status ready");
    wr(0, 8'h50);
    rd(12'h300, "R4 array after clear");
    wr(0, 8'h70);
    rd(0, "R4 status cleared");

    // R12 unrecognised command
    wr(0, 8'h33);
    rd(12'h300, "R12 unknown command");
    wr(0, 8'h00);
    rd(12'h303, "R12 zero command");

    // R6 R10 erase of a data block with neighbours programmed
    prog(12'h6FF, 8'h01);
    prog(12'h700, 8'h02);
    prog(12'h73F, 8'h03);
    prog(12'h740, 8'h04);
    prog(12'h0C0, 8'h05);
    wr(0, 8'h20);
    wr(12'h720, 8'hD0);
    rd(0, "R6 R8 status after erase");
    wr(0, 8'hFF);
    rd(12'h6FF, "R6 R10 main edge");
    rd(12'h700, "R6 R10 data1 start");
    rd(12'h73F, "R6 R10 data1 end");
    rd(12'h740, "R6 R10 data2 start");
    rd(12'h0C0, "R6 R11 other half");

    // R6 R10 R11 bottom data blocks through the inverted bit
    prog(12'h480, 8'h11);
    prog(12'h4BF, 8'h12);
    prog(12'h4C0, 8'h13);
    prog(12'h4FF, 8'h14);
    prog(12'h500, 8'h15);
    wr(0, 8'h20);
    wr(12'h490, 8'hD0);
    wr(0, 8'hFF);
    rd(12'h480, "R6 R10 bottom data1 start");
    rd(12'h4BF, "R6 R10 bottom data1 end");
    rd(12'h4C0, "R6 R10 bottom data2 start");
    rd(12'h4FF, "R6 R10 bottom data2 end");
    rd(12'h500, "R6 R10 bottom main start");

    // R7 erase abort
    prog(12'h200, 8'h9E);
    wr(0, 8'h50);
    wr(0, 8'h20);
    wr(12'h200, 8'hAB);
    rd(12'h200, "R7 status after abort");
    wr(0, 8'hFF);
    rd(12'h200, "R7 array after abort");

    // R8 R9 boot erase completes with ready, nothing else touched
    wr(0, 8'h50);
    wr(0, 8'h20);
    wr(12'h7A0, 8'hD0);
    rd(0, "R8 R9 status after boot erase");
    wr(0, 8'hFF);
    rd(12'h700, "R9 after boot erase");
    rd(12'h300, "R9 after boot erase");

    // R6 main erase
    wr(0, 8'h20);
    wr(12'h0F0, 8'hD0);
    wr(0, 8'hFF);
    rd(12'h300, "R6 main erased");
    rd(12'h740, "R6 outside main");

    idle(4);
    if (sb.size() != 0) begin
      total++; bad++;
      $display("FAIL R2 pending results actual=%0d expected=0", sb.size());
    end
    finish_run();
  end

endmodule